// File: doc/BRIEF.md
# Bidirectional TFT Gate Scan Register

This block is the logic core of a panel gate driver with 300 gate lines. A single vertical start bit enters at one of two cascade pins. Each rising edge of a shift clock moves it one stage along a chain, and each stage drives one gate line. A direction input sets which way the bit travels. It also sets which pin of each paired cascade, shift-clock and blanking pin is the input and which is the output. Several drivers can therefore be chained in either scan direction. Logic 1 on a gate line stands for the high panel rail and logic 0 for the low rail. Each bidirectional pad appears as three ports: an input, an output and an output-enable.

A two-bit length select gives a 300-, 263- or 256-stage chain. The shorter lengths skip a fixed band in the middle of the chain. The stages on either side of the band are joined directly, and every gate line inside the band stays low. A blanking input pulls the active gate lines low. An active-low display-on input drives every active gate line high and also wipes the chain. Both overrides act on the gate lines combinationally, with no wait for a clock. The cascade output register takes the value of the last stage on the falling edge of the shift clock, so the next driver samples a stable bit on its own rising edge.

The shift clock is sampled by the system clock `clk`. An edge of the shift clock is seen at the first `clk` rising edge after it occurs.

Top module: `gate_scan_reg`

## Requirements
- R1: With `dir_fwd`=1, the bit on `cas_a_in` is loaded into G1 (`gate[0]`) on a shift-clock rising edge. Each stage moves toward G300 (`gate[299]`) by one position per rising edge.
- R2: With `dir_fwd`=0, the bit on `cas_b_in` is loaded into G300, and the chain moves toward G1 by one position per rising edge.
- R3: The cascade output register changes only on a shift-clock falling edge, or when it is wiped. It then takes the last stage in the scan direction: G300 going forward, G1 going backward. In the 300-stage chain, a bit loaded on rising edge 1 appears after the fall that follows rising edge 300.
- R4: `mode_sel`=2'b10 gives the 263-stage chain. Stages G133 to G169 are skipped, and G132 and G170 are linked directly in both directions. A bit loaded on edge 1 reaches the cascade output after edge 263.
- R5: `mode_sel`=2'b01 gives the 256-stage chain. Stages G129 to G172 are skipped, and G128 and G173 are linked directly. A bit loaded on edge 1 reaches the cascade output after edge 256.
- R6: `mode_sel`=2'b11, and the reserved value 2'b00, both give the full 300-stage chain.
- R7: A gate line inside the skipped band of the selected length is low at all times, whether or not the blanking or display-on override is active.
- R8: While the input-side blanking pin is high, every gate line is low, without waiting for a clock. Shifting goes on underneath, and once blanking is released each line again shows its stage.
- R9: While `disp_on_n` is low, every gate line outside the skipped band is high, whatever the chain holds and whatever the blanking input does. The chain and the cascade output register are cleared to 0.
- R10: `dir_fwd`=1 makes the A-side cascade, clock and blanking pins inputs and the B-side pins outputs; `dir_fwd`=0 swaps the two sides. Each output-side clock and blanking pin carries the opposite input pin with no clocking. Pins on the output side are ignored as inputs.
- R11: A synchronous active-high `rst` clears every stage and the cascade output register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the shift clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_fwd | input | 1 | Scan direction: 1 = G1 toward G300 |
| mode_sel | input | 2 | Chain length select: 11/00 full, 10 = 263, 01 = 256 |
| disp_on_n | input | 1 | Active-low display-on override |
| cas_a_in | input | 1 | A-side cascade pad, input value |
| cas_a_out | output | 1 | A-side cascade pad, driven value |
| cas_a_oe | output | 1 | A-side cascade pad drive enable |
| cas_b_in | input | 1 | B-side cascade pad, input value |
| cas_b_out | output | 1 | B-side cascade pad, driven value |
| cas_b_oe | output | 1 | B-side cascade pad drive enable |
| sclk_a_in | input | 1 | A-side shift clock pad, input value |
| sclk_a_out | output | 1 | A-side shift clock pad, driven value |
| sclk_a_oe | output | 1 | A-side shift clock pad drive enable |
| sclk_b_in | input | 1 | B-side shift clock pad, input value |
| sclk_b_out | output | 1 | B-side shift clock pad, driven value |
| sclk_b_oe | output | 1 | B-side shift clock pad drive enable |
| blank_a_in | input | 1 | A-side blanking pad, input value |
| blank_a_out | output | 1 | A-side blanking pad, driven value |
| blank_a_oe | output | 1 | A-side blanking pad drive enable |
| blank_b_in | input | 1 | B-side blanking pad, input value |
| blank_b_out | output | 1 | B-side blanking pad, driven value |
| blank_b_oe | output | 1 | B-side blanking pad drive enable |
| gate | output | 300 | Gate line levels, bit i is G(i+1) |

## Verification
Every stage drives its gate line directly. A corrupted or misrouted stage bit therefore shows on `gate` at the first sample after the shift-clock edge that produced it, as long as no override masks it. A fault in the band join shows up as a bit that vanishes or doubles at the G132/G170 or G128/G173 boundary. A fault in the cascade register or its edge choice shows at the cascade pin only after the bit has crossed the whole chain, up to 300 shift edges later. The cascade timing is therefore checked with directed full-length runs in each length and direction. Random runs that mix direction, length, blanking and display-on changes compare the whole gate vector after every step.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

  typedef enum logic [1:0] {
    LEN_FULL   = 2'd0,
    LEN_SKIP_A = 2'd1,
    LEN_SKIP_B = 2'd2
  } len_mode_e;

  function automatic len_mode_e decode_len(input logic [1:0] sel);
    case (sel)
      2'b10:   return LEN_SKIP_A;
      2'b01:   return LEN_SKIP_B;
      default: return LEN_FULL;  // 2'b11 and the reserved 2'b00
    endcase
  endfunction

endpackage

// File: rtl/gsr_pinsteer.sv
module gsr_pinsteer (
  input  logic dir_fwd,
  input  logic cas_q,
  input  logic cas_a_in,
  output logic cas_a_out,
  output logic cas_a_oe,
  input  logic cas_b_in,
  output logic cas_b_out,
  output logic cas_b_oe,
  input  logic sclk_a_in,
  output logic sclk_a_out,
  output logic sclk_a_oe,
  input  logic sclk_b_in,
  output logic sclk_b_out,
  output logic sclk_b_oe,
  input  logic blank_a_in,
  output logic blank_a_out,
  output logic blank_a_oe,
  input  logic blank_b_in,
  output logic blank_b_out,
  output logic blank_b_oe,
  output logic din_sel,
  output logic sclk_sel,
  output logic blank_sel
);

  // input side selection
  assign din_sel   = dir_fwd ? cas_a_in   : cas_b_in;
  assign sclk_sel  = dir_fwd ? sclk_a_in  : sclk_b_in;
  assign blank_sel = dir_fwd ? blank_a_in : blank_b_in;

  // output side drive enables
  assign cas_a_oe   = !dir_fwd;
  assign cas_b_oe   = dir_fwd;
  assign sclk_a_oe  = !dir_fwd;
  assign sclk_b_oe  = dir_fwd;
  assign blank_a_oe = !dir_fwd;
  assign blank_b_oe = dir_fwd;

  // cascade value from the register, clock and blanking passed straight across
  assign cas_a_out   = cas_q;
  assign cas_b_out   = cas_q;
  assign sclk_a_out  = sclk_b_in;
  assign sclk_b_out  = sclk_a_in;
  assign blank_a_out = blank_b_in;
  assign blank_b_out = blank_a_in;

endmodule

// File: rtl/gsr_edge.sv
module gsr_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk_sel,
  output logic rise,
  output logic fall
);

  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk_sel;
  end

  assign rise = sclk_sel && !sclk_q;
  assign fall = !sclk_sel && sclk_q;

endmodule

// File: rtl/gsr_chain.sv
module gsr_chain
  import gsr_pkg::*;
#(
  parameter int NCH    = 300,
  parameter int SKA_LO = 132,
  parameter int SKA_HI = 168,
  parameter int SKB_LO = 128,
  parameter int SKB_HI = 171
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           rise,
  input  logic           fall,
  input  logic           dir_fwd,
  input  len_mode_e      mode,
  input  logic           din,
  output logic [NCH-1:0] stage_q,
  output logic [NCH-1:0] byp,
  output logic           cas_q
);

  localparam int A_BELOW = SKA_LO - 1;
  localparam int A_ABOVE = SKA_HI + 1;
  localparam int B_BELOW = SKB_LO - 1;
  localparam int B_ABOVE = SKB_HI + 1;
  localparam int LAST    = NCH - 1;

  logic [NCH-1:0] stage_d;

  for (genvar g = 0; g < NCH; g++) begin : g_stage
    localparam bit IN_A = (g >= SKA_LO) && (g <= SKA_HI);
    localparam bit IN_B = (g >= SKB_LO) && (g <= SKB_HI);
    logic lo_std, hi_std, lo_src, hi_src;

    if (g == 0) begin : g_lo_edge
      assign lo_std = din;
    end else begin : g_lo_mid
      assign lo_std = stage_q[g-1];
    end

    if (g == LAST) begin : g_hi_edge
      assign hi_std = din;
    end else begin : g_hi_mid
      assign hi_std = stage_q[g+1];
    end

    // forward joins across the skipped band
    if (g == A_ABOVE) begin : g_lo_ja
      assign lo_src = (mode == LEN_SKIP_A) ? stage_q[A_BELOW] : lo_std;
    end else if (g == B_ABOVE) begin : g_lo_jb
      assign lo_src = (mode == LEN_SKIP_B) ? stage_q[B_BELOW] : lo_std;
    end else begin : g_lo_plain
      assign lo_src = lo_std;
    end

    // backward joins across the skipped band
    if (g == A_BELOW) begin : g_hi_ja
      assign hi_src = (mode == LEN_SKIP_A) ? stage_q[A_ABOVE] : hi_std;
    end else if (g == B_BELOW) begin : g_hi_jb
      assign hi_src = (mode == LEN_SKIP_B) ? stage_q[B_ABOVE] : hi_std;
    end else begin : g_hi_plain
      assign hi_src = hi_std;
    end

    assign byp[g]     = (IN_A && (mode == LEN_SKIP_A)) || (IN_B && (mode == LEN_SKIP_B));
    assign stage_d[g] = dir_fwd ? lo_src : hi_src;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  stage_q <= '0;
    else if (rise)   stage_q <= stage_d & ~byp;
    else             stage_q <= stage_q & ~byp;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cas_q <= 1'b0;
    else if (fall)  cas_q <= dir_fwd ? stage_q[LAST] : stage_q[0];
  end

  // R1
  fwd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && !clr && dir_fwd && mode == LEN_FULL) |=> (stage_q[1] == $past(stage_q[0])));

  // R2
  rev_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && !clr && !dir_fwd && mode == LEN_FULL) |=> (stage_q[LAST-1] == $past(stage_q[LAST])));

  // R3
  cas_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fall && !clr) |=> $stable(cas_q));

  // R9
  clr_wipe_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (stage_q == '0 && !cas_q));

  // R7
  band_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == LEN_SKIP_A && $past(mode) == LEN_SKIP_A) |-> (!stage_q[SKA_LO] && !stage_q[SKA_HI]));

endmodule

// File: rtl/gsr_gatedrv.sv
module gsr_gatedrv #(
  parameter int NCH = 300
) (
  input  logic [NCH-1:0] stage_q,
  input  logic [NCH-1:0] byp,
  input  logic           blank,
  input  logic           disp_on_n,
  output logic [NCH-1:0] gate
);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (byp[i])          gate[i] = 1'b0;
      else if (!disp_on_n) gate[i] = 1'b1;
      else if (blank)      gate[i] = 1'b0;
      else                 gate[i] = stage_q[i];
    end
  end

endmodule

// File: rtl/gate_scan_reg.sv
module gate_scan_reg
  import gsr_pkg::*;
#(
  parameter int NCH    = 300,
  parameter int SKA_LO = 132,
  parameter int SKA_HI = 168,
  parameter int SKB_LO = 128,
  parameter int SKB_HI = 171
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dir_fwd,
  input  logic [1:0]     mode_sel,
  input  logic           disp_on_n,
  input  logic           cas_a_in,
  output logic           cas_a_out,
  output logic           cas_a_oe,
  input  logic           cas_b_in,
  output logic           cas_b_out,
  output logic           cas_b_oe,
  input  logic           sclk_a_in,
  output logic           sclk_a_out,
  output logic           sclk_a_oe,
  input  logic           sclk_b_in,
  output logic           sclk_b_out,
  output logic           sclk_b_oe,
  input  logic           blank_a_in,
  output logic           blank_a_out,
  output logic           blank_a_oe,
  input  logic           blank_b_in,
  output logic           blank_b_out,
  output logic           blank_b_oe,
  output logic [NCH-1:0] gate
);

  len_mode_e      mode;
  logic           din_sel, sclk_sel, blank_sel;
  logic           rise, fall, cas_q;
  logic [NCH-1:0] stage_q, byp;

  assign mode = decode_len(mode_sel);

  gsr_pinsteer u_steer (
    .dir_fwd     (dir_fwd),
    .cas_q       (cas_q),
    .cas_a_in    (cas_a_in),
    .cas_a_out   (cas_a_out),
    .cas_a_oe    (cas_a_oe),
    .cas_b_in    (cas_b_in),
    .cas_b_out   (cas_b_out),
    .cas_b_oe    (cas_b_oe),
    .sclk_a_in   (sclk_a_in),
    .sclk_a_out  (sclk_a_out),
    .sclk_a_oe   (sclk_a_oe),
    .sclk_b_in   (sclk_b_in),
    .sclk_b_out  (sclk_b_out),
    .sclk_b_oe   (sclk_b_oe),
    .blank_a_in  (blank_a_in),
    .blank_a_out (blank_a_out),
    .blank_a_oe  (blank_a_oe),
    .blank_b_in  (blank_b_in),
    .blank_b_out (blank_b_out),
    .blank_b_oe  (blank_b_oe),
    .din_sel     (din_sel),
    .sclk_sel    (sclk_sel),
    .blank_sel   (blank_sel)
  );

  gsr_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .sclk_sel (sclk_sel),
    .rise     (rise),
    .fall     (fall)
  );

  gsr_chain #(
    .NCH    (NCH),
    .SKA_LO (SKA_LO),
    .SKA_HI (SKA_HI),
    .SKB_LO (SKB_LO),
    .SKB_HI (SKB_HI)
  ) u_chain (
    .clk     (clk),
    .rst     (rst),
    .clr     (!disp_on_n),
    .rise    (rise),
    .fall    (fall),
    .dir_fwd (dir_fwd),
    .mode    (mode),
    .din     (din_sel),
    .stage_q (stage_q),
    .byp     (byp),
    .cas_q   (cas_q)
  );

  gsr_gatedrv #(
    .NCH (NCH)
  ) u_drv (
    .stage_q   (stage_q),
    .byp       (byp),
    .blank     (blank_sel),
    .disp_on_n (disp_on_n),
    .gate      (gate)
  );

  // R10
  side_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (cas_a_oe != cas_b_oe) && (sclk_a_oe == cas_a_oe) && (blank_b_oe == cas_b_oe));

endmodule

// File: tb/gate_scan_reg_tb_top.sv
module gate_scan_reg_tb_top;

  localparam int NCH = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir_fwd = 1'b1;
  logic [1:0] mode_sel = 2'b11;
  logic disp_on_n = 1'b1;
  logic drv_din = 1'b0, drv_sclk = 1'b0, drv_blank = 1'b0;
  logic junk_a = 1'b0, junk_b = 1'b0;

  logic cas_a_out, cas_a_oe, cas_b_out, cas_b_oe;
  logic sclk_a_out, sclk_a_oe, sclk_b_out, sclk_b_oe;
  logic blank_a_out, blank_a_oe, blank_b_out, blank_b_oe;
  logic [NCH-1:0] gate;

  logic cas_a_in, cas_b_in, sclk_a_in, sclk_b_in, blank_a_in, blank_b_in;
  assign cas_a_in   = dir_fwd ? drv_din   : junk_a;
  assign cas_b_in   = dir_fwd ? junk_b    : drv_din;
  assign sclk_a_in  = dir_fwd ? drv_sclk  : junk_a;
  assign sclk_b_in  = dir_fwd ? junk_b    : drv_sclk;
  assign blank_a_in = dir_fwd ? drv_blank : junk_b;
  assign blank_b_in = dir_fwd ? junk_a    : drv_blank;

  always #5 clk = ~clk;

  gate_scan_reg dut_i (
    .clk(clk), .rst(rst), .dir_fwd(dir_fwd), .mode_sel(mode_sel), .disp_on_n(disp_on_n),
    .cas_a_in(cas_a_in), .cas_a_out(cas_a_out), .cas_a_oe(cas_a_oe),
    .cas_b_in(cas_b_in), .cas_b_out(cas_b_out), .cas_b_oe(cas_b_oe),
    .sclk_a_in(sclk_a_in), .sclk_a_out(sclk_a_out), .sclk_a_oe(sclk_a_oe),
    .sclk_b_in(sclk_b_in), .sclk_b_out(sclk_b_out), .sclk_b_oe(sclk_b_oe),
    .blank_a_in(blank_a_in), .blank_a_out(blank_a_out), .blank_a_oe(blank_a_oe),
    .blank_b_in(blank_b_in), .blank_b_out(blank_b_out), .blank_b_oe(blank_b_oe),
    .gate(gate)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [NCH-1:0] m_st = '0;
  logic m_cas = 1'b0;

  function automatic bit m_byp(int i, logic [1:0] sel);
    if (sel == 2'b10) return (i >= 132) && (i <= 168);  // G133..G169
    if (sel == 2'b01) return (i >= 128) && (i <= 171);  // G129..G172
    return 1'b0;
  endfunction

  function automatic logic [NCH-1:0] m_mask(logic [1:0] sel);
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[i] = m_byp(i, sel);
    return r;
  endfunction

  function automatic logic [NCH-1:0] m_shift(logic [NCH-1:0] s, logic d, logic fwd, logic [1:0] sel);
    logic [NCH-1:0] r;
    logic c;
    r = '0;
    c = d;
    if (fwd) begin
      for (int i = 0; i < NCH; i++)
        if (!m_byp(i, sel)) begin r[i] = c; c = s[i]; end
    end else begin
      for (int i = NCH - 1; i >= 0; i--)
        if (!m_byp(i, sel)) begin r[i] = c; c = s[i]; end
    end
    return r;
  endfunction

  function automatic logic [NCH-1:0] m_gates();
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) begin
      if (m_byp(i, mode_sel)) r[i] = 1'b0;
      else if (!disp_on_n)    r[i] = 1'b1;
      else if (drv_blank)     r[i] = 1'b0;
      else                    r[i] = m_st[i];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_gates(input string req);
    logic [NCH-1:0] e;
    #1;
    e = m_gates();
    chk(gate === e, req, "gate", gate, e);
  endtask

  task automatic check_cas(input string req);
    logic o;
    #1;
    o = dir_fwd ? cas_b_out : cas_a_out;
    chk(o === m_cas, req, "cascade", {{(NCH-1){1'b0}}, o}, {{(NCH-1){1'b0}}, m_cas});
  endtask

  task automatic check_pins(input string req);
    bit ok;
    #1;
    ok = (cas_b_oe === dir_fwd) && (cas_a_oe === !dir_fwd) &&
         (sclk_b_oe === dir_fwd) && (sclk_a_oe === !dir_fwd) &&
         (blank_b_oe === dir_fwd) && (blank_a_oe === !dir_fwd) &&
         (sclk_a_out === sclk_b_in) && (sclk_b_out === sclk_a_in) &&
         (blank_a_out === blank_b_in) && (blank_b_out === blank_a_in);
    chk(ok, req, "pin steering", {{(NCH-1){1'b0}}, ~ok}, '0);
  endtask

  task automatic pulse(input logic d);
    @(negedge clk);
    drv_din = d; drv_sclk = 1'b1; junk_a = $urandom; junk_b = $urandom;
    @(negedge clk);
    drv_sclk = 1'b0;
    @(negedge clk);
    if (disp_on_n) begin
      m_st  = m_shift(m_st, d, dir_fwd, mode_sel);
      m_cas = dir_fwd ? m_st[NCH-1] : m_st[0];
    end
  endtask

  task automatic set_mode(input logic [1:0] s);
    @(negedge clk); mode_sel = s;
    @(negedge clk); m_st = m_st & ~m_mask(s);
  endtask

  task automatic set_dir(input logic d);
    @(negedge clk); dir_fwd = d;
    @(negedge clk);
  endtask

  task automatic disp_burst(input string req);
    @(negedge clk); disp_on_n = 1'b0;
    check_gates(req);
    @(negedge clk); disp_on_n = 1'b1;
    m_st = '0; m_cas = 1'b0;
    check_gates(req);
    check_cas(req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; m_st = '0; m_cas = 1'b0;
  endtask

  task automatic length_run(input logic [1:0] s, input logic d, input int len, input string req);
    do_reset();
    set_mode(s);
    set_dir(d);
    pulse(1'b1);
    check_gates(req);
    for (int k = 2; k <= len; k++) begin
      pulse(1'b0);
      if (k == len - 1) begin
        check_cas(req);
        chk(m_cas == 1'b0, req, "model cascade early", '0, '0);
      end
    end
    check_gates(req);
    check_cas(req);
    chk(m_cas == 1'b1, req, "cascade at chain end", {{(NCH-1){1'b0}}, m_cas}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check_gates("R11");
    check_cas("R11");
    check_pins("R10");

    // R1 / R3 forward full length
    length_run(2'b11, 1'b1, 300, "R1 R3");
    // R2 / R3 backward full length
    length_run(2'b11, 1'b0, 300, "R2 R3");
    // R4 263-stage chain both directions
    length_run(2'b10, 1'b1, 263, "R4");
    length_run(2'b10, 1'b0, 263, "R4");
    // R5 256-stage chain both directions
    length_run(2'b01, 1'b1, 256, "R5");
    length_run(2'b01, 1'b0, 256, "R5");
    // R6 reserved code is the full chain
    length_run(2'b00, 1'b1, 300, "R6");

    // R4 join check: bit at G132 moves to G170 on one edge
    do_reset();
    set_mode(2'b10);
    for (int k = 1; k <= 133; k++) pulse(k == 1);
    check_gates("R4 join");
    chk(gate[169] === 1'b1, "R4", "G170 after join", gate, m_gates());

    // R7 band stays low under display-on
    set_mode(2'b01);
    @(negedge clk); disp_on_n = 1'b0;
    check_gates("R7");
    chk(gate[150] === 1'b0 && gate[0] === 1'b1, "R7", "band low under display-on", gate, m_gates());
    @(negedge clk); disp_on_n = 1'b1; m_st = '0; m_cas = 1'b0;

    // R8 blanking overrides, shifting continues underneath
    do_reset();
    for (int k = 0; k < 8; k++) pulse(1'b1);
    @(negedge clk); drv_blank = 1'b1;
    check_gates("R8");
    chk(gate === '0, "R8", "all low when blanked", gate, '0);
    pulse(1'b0); pulse(1'b1);
    check_gates("R8");
    @(negedge clk); drv_blank = 1'b0;
    check_gates("R8");

    // R9 display-on wipes and forces high
    disp_burst("R9");

    // R10 pins on output side are ignored as inputs
    set_dir(1'b0);
    check_pins("R10");
    pulse(1'b1);
    check_gates("R10");
    set_dir(1'b1);
    check_pins("R10");

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 70) begin
        pulse($urandom_range(0, 3) == 0);
        check_gates("R1 R2");
        check_cas("R3");
      end else if (r < 75) begin
        set_dir(~dir_fwd);
        check_pins("R10");
        check_gates("R10");
      end else if (r < 82) begin
        set_mode(2'($urandom_range(0, 3)));
        check_gates("R7");
      end else if (r < 95) begin
        @(negedge clk); drv_blank = ~drv_blank;
        check_gates("R8");
      end else begin
        disp_burst("R9");
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule